// File: doc/BRIEF.md
# Stereo Pilot Subcarrier Divider Chain

This block sits between the 76 kHz voltage-controlled oscillator of an FM stereo decoder and the analog detectors it feeds. The oscillator's pulse train arrives as a one-cycle clock enable, `vco_en`. From it the block derives three square waves:

- a 38 kHz subcarrier for the stereo demodulator;
- a 19 kHz quadrature reference for the pilot phase detector;
- a 19 kHz in-phase reference for the pilot amplitude detector.

The in-phase divider is steered by both the 38 kHz stage and the quadrature divider. Because of this, its phase relation to the quadrature reference is fixed and can never settle half a cycle off.

A small digital qualifier watches the pilot-detected flag from the amplitude detector. It raises the stereo enable, which drives the indicator lamp and the demodulator switch, only after the flag has held for a programmable number of 19 kHz cycles. It drops the enable in the same clock cycle that the flag falls.

Top module: `pilot_divider_chain`

## Requirements
- R1: `sub38` inverts on every clock edge where `vco_en` is 1, so it is `vco_en` divided by two.
- R2: `ref19_quad` inverts on exactly those `vco_en` edges where `sub38` was 0 before the edge. It therefore rises together with `sub38` and has a period of four `vco_en` pulses.
- R3: `ref19_inph` equals the value `ref19_quad` had one `vco_en` pulse earlier (a quarter of a 19 kHz cycle later). It equals `ref19_quad` whenever `sub38` is 0 and is the inverse whenever `sub38` is 1.
- R4: A synchronous reset (`rst` = 1 at a clock edge) sets `sub38`, `ref19_quad` and `ref19_inph` to 0 and clears the qualifier count.
- R5: On clock edges without `vco_en`, none of the three divider outputs changes.
- R6: While `pilot_det` is 1, each rising edge of `ref19_quad` counts one 19 kHz cycle. `stereo_en` goes to 1 once the count reaches `hold_cycles` and stays at 1 while `pilot_det` holds.
- R7: `stereo_en` is 0 in the same cycle `pilot_det` is 0, and the count restarts from zero.
- R8: With `hold_cycles` = 0, `stereo_en` follows `pilot_det` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vco_en | input | 1 | One-cycle pulse per 76 kHz oscillator period |
| pilot_det | input | 1 | Pilot-present flag from the amplitude detector |
| hold_cycles | input | CNT_W | Number of 19 kHz cycles the pilot must hold before stereo is enabled |
| sub38 | output | 1 | 38 kHz subcarrier square wave |
| ref19_quad | output | 1 | 19 kHz quadrature reference |
| ref19_inph | output | 1 | 19 kHz in-phase reference |
| stereo_en | output | 1 | Stereo demodulator enable and lamp drive |

## Verification
The bench builds the block with CNT_W = 4. This makes the largest hold setting, 15 cycles (60 oscillator pulses), short enough to reach, so that the count's saturation at full scale is exercised alongside hold settings of 0, 1 and 3. Oscillator pulses are spaced by irregular idle gaps, and the bench checks the three-phase divider pattern against a tick-indexed model over several full 19 kHz periods. It also checks the phase again after a reset applied in the middle of the sequence.

// File: rtl/pilot_divider_chain.sv
module pilot_divider_chain #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vco_en,
  input  logic             pilot_det,
  input  logic [CNT_W-1:0] hold_cycles,
  output logic             sub38,
  output logic             ref19_quad,
  output logic             ref19_inph,
  output logic             stereo_en
);

  logic [CNT_W-1:0] cnt;
  logic             edge19;
  logic             qualified;

  assign edge19    = vco_en & ~sub38 & ~ref19_quad;
  assign qualified = (cnt >= hold_cycles);
  assign stereo_en = pilot_det & qualified;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub38      <= 1'b0;
      ref19_quad <= 1'b0;
      ref19_inph <= 1'b0;
    end else if (vco_en) begin
      sub38 <= ~sub38;
      if (!sub38) ref19_quad <= ~ref19_quad;
      else        ref19_inph <= ref19_quad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pilot_det)         cnt <= '0;
    else if (edge19 && !qualified) cnt <= cnt + 1'b1;
  end

  // R1
  half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    vco_en |=> sub38 != $past(sub38));

  // R2
  quad_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vco_en && !sub38) |=> ref19_quad != $past(ref19_quad));

  // R3
  phase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sub38 ? (ref19_inph != ref19_quad) : (ref19_inph == ref19_quad));

  // R4
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sub38 && !ref19_quad && !ref19_inph && cnt == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vco_en |=> $stable({sub38, ref19_quad, ref19_inph}));

endmodule

// File: tb/test_pilot_divider_chain.sv
module test_pilot_divider_chain;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vco_en = 1'b0;
  logic pilot_det = 1'b0;
  logic [CNT_W-1:0] hold_cycles = '0;
  logic sub38, ref19_quad, ref19_inph, stereo_en;

  int vectors = 0;
  int miscompares = 0;
  int k = 0;

  always #4 clk = ~clk;

  pilot_divider_chain #(.CNT_W(CNT_W)) i_pilot_divider_chain (
    .clk(clk), .rst(rst), .vco_en(vco_en), .pilot_det(pilot_det),
    .hold_cycles(hold_cycles), .sub38(sub38), .ref19_quad(ref19_quad),
    .ref19_inph(ref19_inph), .stereo_en(stereo_en));

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b (tick %0d)", req, act, exp, k);
    end
  endtask

  task automatic check_phase(input string req);
    int m = k % 4;
    check({req, " sub38"}, sub38, (m % 2) == 1);
    check({req, " quad"}, ref19_quad, m == 1 || m == 2);
    check({req, " inph"}, ref19_inph, m == 2 || m == 3);
  endtask

  task automatic tick(input int gap);
    @(negedge clk) vco_en = 1'b1;
    @(negedge clk) vco_en = 1'b0;
    k++;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    k = 0;
  endtask

  task automatic test_reset();
    do_reset();
    check_phase("R4 reset");
    check("R4 stereo after reset", stereo_en, 1'b0);
  endtask

  task automatic test_sequence();
    for (int n = 0; n < 16; n++) begin
      tick(n % 3);
      check_phase("R1 R2 R3 sequence");
    end
  endtask

  task automatic test_idle();
    logic s, q, i;
    s = sub38; q = ref19_quad; i = ref19_inph;
    repeat (7) @(negedge clk);
    check("R5 idle sub38", sub38, s);
    check("R5 idle quad", ref19_quad, q);
    check("R5 idle inph", ref19_inph, i);
  endtask

  task automatic test_mid_reset();
    tick(0);
    tick(1);
    tick(0);
    do_reset();
    check_phase("R4 mid reset");
    tick(0);
    check_phase("R4 after mid reset");
  endtask

  task automatic test_qualify(input int h);
    int edges = 0;
    do_reset();
    @(negedge clk) hold_cycles = CNT_W'(h);
    pilot_det = 1'b1;
    #1 check("R6 initial", stereo_en, h == 0);
    for (int n = 0; n < 4 * h + 8; n++) begin
      tick(n % 2);
      if (k % 4 == 1) edges++;
      check("R6 qualify", stereo_en, edges >= h);
    end
  endtask

  task automatic test_drop();
    @(negedge clk) pilot_det = 1'b0;
    #1 check("R7 drop same cycle", stereo_en, 1'b0);
    @(negedge clk) pilot_det = 1'b1;
    #1 check("R7 count restarted", stereo_en, hold_cycles == 0);
    @(negedge clk) pilot_det = 1'b0;
  endtask

  task automatic test_zero_hold();
    @(negedge clk) hold_cycles = '0;
    pilot_det = 1'b1;
    #1 check("R8 follow high", stereo_en, 1'b1);
    @(negedge clk) pilot_det = 1'b0;
    #1 check("R8 follow low", stereo_en, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    test_sequence();
    test_idle();
    test_mid_reset();
    test_qualify(3);
    test_drop();
    test_qualify(1);
    test_drop();
    test_qualify(15);
    test_drop();
    test_qualify(0);
    test_zero_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule